// File: doc/BRIEF.md
# Multiplexed RGB Column PWM Driver

This block lights a matrix of LEDs in which sixteen column lines are shared by three color rows. It runs the rows one after another (red, then green, then blue, then red again) and gives each row one full revolution of a free-running 8-bit tick counter. During a row's turn, every column is switched on at the start of the period and switched off when the tick counter reaches that column's brightness for the row's color. The result is a pulse-width-modulated column bus that changes meaning with the row select.

A host writes the 48 brightness bytes through a simple write port, addressed by color and column. The writes land in shadow storage. The shadow bytes of one color are copied into the working set only at the moment that color's row period begins, so a row period never mixes old and new values. The tick counter advances once every `PRESCALE` clock cycles. At every row change the columns are forced low for one clock before the next row select is raised.

Top module: `rgb_mux_pwm`

## Requirements
- R1: After reset, `row_sel` and `col_out` are all zero, and every stored brightness is zero, so the first periods after reset show all columns dark.
- R2: At most one bit of `row_sel` is high in any cycle.
- R3: Row periods follow the order red (`row_sel`=001), green (010), blue (100) and then repeat. Each row select stays high for 256*PRESCALE-1 clocks.
- R4: Between two row periods, `row_sel` is zero for exactly one clock, and `col_out` is all zero in every cycle in which `row_sel` is zero.
- R5: A column whose brightness for the current color is 0 stays low for the whole row period.
- R6: A column with brightness v in 1..254 is high for exactly v*PRESCALE-1 clocks. It rises together with the row select and falls on the tick at which the counter reaches v. Columns with equal values fall in the same clock.
- R7: A brightness of 255 keeps the column high for 255*PRESCALE-1 clocks, which is every tick of the period except the last.
- R8: A write changes only shadow storage. The new value of color c first shows in the next row period of color c that begins after the write, and a row period that is already running keeps its old values.
- R9: `wr_color` 0, 1 and 2 address red, green and blue, and `wr_col` = i addresses `col_out[i]`. Writes with `wr_color` = 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Brightness write strobe, one byte per cycle |
| wr_color | input | 2 | Color of the written byte: 0 red, 1 green, 2 blue |
| wr_col | input | COL_AW (4) | Column of the written byte |
| wr_data | input | VAL_W (8) | Brightness value |
| col_out | output | NUM_COLS (16) | Shared column drive, bit i is column i |
| row_sel | output | 3 | One-hot row select: bit 0 red, bit 1 green, bit 2 blue |

## Verification
The bench builds the block with PRESCALE set to 4 and keeps the other parameters at their defaults. A row period then lasts 1024 clocks and a full three-color frame lasts 3072 clocks. This makes it possible to run several frames in one run. Those frames cover the all-zero start-up values, a complete reload of all 48 bytes, and a green update written while a green period is already running. In every period the bench measures the exact pulse width of all sixteen columns, including values 0, 1 and 255 and groups of columns with equal values.

// File: rtl/rgb_mux_pkg.sv
// Package: shared row encoding and helpers for the multiplexed RGB driver.
// Assumes exactly three rows visited in the order red, green, blue.
package rgb_mux_pkg;

    localparam int NUM_ROWS = 3;

    typedef enum logic [1:0] {
        ROW_RED = 2'd0,
        ROW_GRN = 2'd1,
        ROW_BLU = 2'd2
    } row_e;

    // Successor of a row in the fixed visiting order.
    function automatic row_e row_after(input row_e cur);
        case (cur)
            ROW_RED: row_after = ROW_GRN;
            ROW_GRN: row_after = ROW_BLU;
            default: row_after = ROW_RED;
        endcase
    endfunction

endpackage

// File: rtl/tick_divider.sv
// Module: tick_divider
// Emits a one-clock tick every PRESCALE clocks. Assumes PRESCALE >= 2,
// so that a tick never falls on two consecutive clocks.
module tick_divider #(
    parameter int PRESCALE = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] div_q;

    // Wrapping divide-by-PRESCALE counter.
    always_ff @(posedge clk) begin
        if (!rst_n)           div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                  div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);

endmodule

// File: rtl/row_sequencer.sv
// Module: row_sequencer
// Holds the tick counter and the current row. On the tick on which the counter
// wraps, it blanks the row select, advances the row and requests a reload of
// that row's brightness. One clock later it raises the new row select and arms
// the columns. Assumes tick is never high on two consecutive clocks.
module row_sequencer
    import rgb_mux_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             blank,
    output logic             arm,
    output row_e             load_row,
    output logic [2:0]       row_sel
);
    row_e row_q;
    logic arm_q;

    assign blank    = tick && (cnt == '1);
    assign load_row = row_after(row_q);
    assign arm      = arm_q;

    // Free-running tick counter. It starts at all-ones so that the first tick is a row boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '1;
        else if (tick) cnt <= cnt + 1'b1;
    end

    // Current row. It starts at blue so that the first boundary selects red.
    always_ff @(posedge clk) begin
        if (!rst_n)     row_q <= ROW_BLU;
        else if (blank) row_q <= load_row;
    end

    // Delays the boundary by one clock to give the blanking gap.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= blank;
    end

    // Row select output: dropped at the boundary, raised after the gap.
    always_ff @(posedge clk) begin
        if (!rst_n)     row_sel <= 3'b000;
        else if (blank) row_sel <= 3'b000;
        else if (arm_q) row_sel <= 3'b001 << row_q;
    end

    // Checker state: the last row select that was active.
    logic [2:0] chk_last;
    always_ff @(posedge clk) begin
        if (!rst_n)               chk_last <= 3'b000;
        else if (row_sel != 3'b0) chk_last <= row_sel;
    end

    // R2: never more than one row select.
    a_r2_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel));

    // R3: a newly raised row select is the successor of the previous one.
    a_r3_row_order: assert property (@(posedge clk) disable iff (!rst_n)
        (row_sel != 3'b0 && $past(row_sel) == 3'b0 && chk_last != 3'b0)
        |-> row_sel == {chk_last[1:0], chk_last[2]});

    // R4: a row select always drops for at least one clock at a counter wrap.
    a_r4_row_drop: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> row_sel == 3'b000);

endmodule

// File: rtl/brightness_bank.sv
// Module: brightness_bank
// Shadow storage for all colors, written by the host, plus the working set for
// the row being shown. The working set is loaded from the shadow of load_row
// only when load is high. Writes with an out-of-range color are dropped.
module brightness_bank
    import rgb_mux_pkg::*;
#(
    parameter int NUM_COLS = 16,
    parameter int VAL_W    = 8,
    parameter int COL_AW   = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [1:0]                     wr_color,
    input  logic [COL_AW-1:0]              wr_col,
    input  logic [VAL_W-1:0]               wr_data,
    input  logic                           load,
    input  row_e                           load_row,
    output logic [NUM_COLS-1:0][VAL_W-1:0] active
);
    logic [NUM_COLS-1:0][VAL_W-1:0] shadow [NUM_ROWS];
    logic wr_ok;

    assign wr_ok = wr_en && (int'(wr_color) < NUM_ROWS) && (int'(wr_col) < NUM_COLS);

    // Host writes into the shadow storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_ROWS; r++) shadow[r] <= '0;
        end else if (wr_ok) begin
            shadow[wr_color][wr_col] <= wr_data;
        end
    end

    // Working set for the shown row, loaded only at the row boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    active <= '0;
        else if (load) active <= shadow[load_row];
    end

    // R8: the working set never changes between boundaries.
    a_r8_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active));

endmodule

// File: rtl/column_lane.sv
// Module: column_lane
// One PWM column. It is cleared at the boundary, set at arm when its value is
// nonzero, and cleared on the tick at which the counter becomes its value.
// Assumes arm and tick never fall on the same clock.
module column_lane #(
    parameter int VAL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blank,
    input  logic             arm,
    input  logic             tick,
    input  logic [VAL_W-1:0] cnt,
    input  logic [VAL_W-1:0] val,
    output logic             lit
);
    logic [VAL_W-1:0] cnt_nx;
    assign cnt_nx = cnt + 1'b1;

    // Column on/off state for the current row period.
    always_ff @(posedge clk) begin
        if (!rst_n)                         lit <= 1'b0;
        else if (blank)                     lit <= 1'b0;
        else if (arm)                       lit <= (val != '0);
        else if (tick && (cnt_nx == val))   lit <= 1'b0;
    end

    // R5: a zero value never lights the column.
    a_r5_zero_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && val == '0) |=> !lit);

    // R6: the column is dark right after the counter reaches its value.
    a_r6_off_at_match: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !blank && cnt_nx == val) |=> !lit);

    // R6: a column can only rise at arm.
    a_r6_rise_at_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (!lit && !arm) |=> !lit);

endmodule

// File: rtl/rgb_mux_pwm.sv
// Module: rgb_mux_pwm (top)
// Sixteen shared column outputs, PWM-driven for three time-multiplexed color
// rows. Each row gets 256 ticks of PRESCALE clocks. Columns are blanked for one
// clock at each row change. Brightness writes take effect at the next period
// of their color. Assumes PRESCALE >= 2.
module rgb_mux_pwm
    import rgb_mux_pkg::*;
#(
    parameter int NUM_COLS = 16,
    parameter int VAL_W    = 8,
    parameter int PRESCALE = 64,
    parameter int COL_AW   = $clog2(NUM_COLS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_color,
    input  logic [COL_AW-1:0]   wr_col,
    input  logic [VAL_W-1:0]    wr_data,
    output logic [NUM_COLS-1:0] col_out,
    output logic [2:0]          row_sel
);
    logic                           tick;
    logic [VAL_W-1:0]               cnt;
    logic                           blank;
    logic                           arm;
    row_e                           load_row;
    logic [NUM_COLS-1:0][VAL_W-1:0] active;

    tick_divider #(.PRESCALE(PRESCALE)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    row_sequencer #(.CNT_W(VAL_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cnt      (cnt),
        .blank    (blank),
        .arm      (arm),
        .load_row (load_row),
        .row_sel  (row_sel)
    );

    brightness_bank #(
        .NUM_COLS (NUM_COLS),
        .VAL_W    (VAL_W),
        .COL_AW   (COL_AW)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_color (wr_color),
        .wr_col   (wr_col),
        .wr_data  (wr_data),
        .load     (blank),
        .load_row (load_row),
        .active   (active)
    );

    for (genvar g = 0; g < NUM_COLS; g++) begin : g_lane
        column_lane #(.VAL_W(VAL_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .blank (blank),
            .arm   (arm),
            .tick  (tick),
            .cnt   (cnt),
            .val   (active[g]),
            .lit   (col_out[g])
        );
    end

    // R4: columns are dark whenever no row is selected.
    a_r4_blank_cols: assert property (@(posedge clk) disable iff (!rst_n)
        (row_sel == 3'b000) |-> (col_out == '0));

endmodule

// File: tb/tb_rgb_mux_pwm.sv
// Scoreboard bench: the driver pushes the expected content of upcoming row
// periods, and the monitor measures every period and compares it.
module tb_rgb_mux_pwm;
    localparam int NC = 16;
    localparam int P  = 4;
    localparam int ROW_CLKS = 256 * P - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_color = '0;
    logic [3:0]    wr_col = '0;
    logic [7:0]    wr_data = '0;
    logic [NC-1:0] col_out;
    logic [2:0]    row_sel;

    always #4 clk = ~clk;  // 125 MHz

    rgb_mux_pwm #(.NUM_COLS(NC), .VAL_W(8), .PRESCALE(P)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_color(wr_color),
        .wr_col(wr_col), .wr_data(wr_data), .col_out(col_out), .row_sel(row_sel)
    );

    typedef struct {
        int    row;
        int    vals[NC];
        string tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int tbl[NC] = '{0, 1, 255, 1, 5, 5, 128, 0, 2, 200, 255, 17, 64, 64, 3, 100};
    int set_a[3][NC];
    int set_c[NC];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int row, input int v[NC], input string tag);
        exp_t e;
        e.row = row;
        e.vals = v;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wr(input int c, input int col, input int v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_color = 2'(c);
        wr_col = 4'(col);
        wr_data = 8'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_row_start(input int row);
        logic [2:0] prev;
        prev = row_sel;
        forever begin
            @(negedge clk);
            if (prev == 3'b000 && row_sel == (3'b001 << row)) break;
            prev = row_sel;
        end
        repeat (2) @(negedge clk);
    endtask

    // Monitor: measures each row period and compares it with the scoreboard.
    initial begin
        logic [2:0] prev_sel;
        int hi[NC];
        int row_len;
        int gap;
        bit gap_valid;
        bit have_exp;
        bit blank_bad;
        bit multi_bad;
        exp_t cur;
        prev_sel = 3'b000;
        row_len = 0; gap = 0; gap_valid = 0; have_exp = 0; blank_bad = 0; multi_bad = 0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if ($countones(row_sel) > 1) multi_bad = 1;
            if (row_sel == 3'b000 && col_out != '0) blank_bad = 1;
            if (prev_sel == 3'b000 && row_sel != 3'b000) begin
                if (gap_valid) chk(gap == 1, "R4", "blank gap clocks", gap, 1);
                have_exp = (q.size() > 0);
                if (have_exp) cur = q.pop_front();
                row_len = 0;
                for (int i = 0; i < NC; i++) hi[i] = 0;
            end
            if (row_sel != 3'b000) begin
                row_len++;
                for (int i = 0; i < NC; i++) hi[i] += int'(col_out[i]);
            end
            if (prev_sel != 3'b000 && row_sel == 3'b000) begin
                if (have_exp) begin
                    int ex_sel;
                    ex_sel = 1 << cur.row;
                    chk(int'(prev_sel) == ex_sel, "R3", {cur.tag, " row order"}, int'(prev_sel), ex_sel);
                    chk(row_len == ROW_CLKS, "R3", "row select width", row_len, ROW_CLKS);
                    chk(!blank_bad, "R4", "columns low while no row", int'(blank_bad), 0);
                    chk(!multi_bad, "R2", "single row select", int'(multi_bad), 0);
                    for (int i = 0; i < NC; i++) begin
                        int v;
                        int ew;
                        string rq;
                        v = cur.vals[i];
                        ew = (v == 0) ? 0 : v * P - 1;
                        rq = (v == 0) ? "R5" : (v == 255) ? "R7" : "R6";
                        chk(hi[i] == ew, rq, $sformatf("%s col %0d width (v=%0d)", cur.tag, i, v), hi[i], ew);
                    end
                end
                have_exp = 0;
                gap = 0;
                gap_valid = 1;
            end
            if (row_sel == 3'b000) gap++;
            prev_sel = row_sel;
        end
    end

    // Watchdog: an expired run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Driver.
    initial begin
        int zero[NC];
        for (int i = 0; i < NC; i++) begin
            zero[i] = 0;
            set_a[0][i] = tbl[i];
            set_a[1][i] = tbl[(i + 5) % NC];
            set_a[2][i] = tbl[NC - 1 - i];
            set_c[i] = i * 16 + 7;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(row_sel == 3'b000, "R1", "row_sel after reset", int'(row_sel), 0);
        chk(col_out == '0, "R1", "col_out after reset", int'(col_out), 0);
        // R1: start-up brightness is zero for all colors.
        push(0, zero, "R1");
        push(1, zero, "R1");
        push(2, zero, "R1");

        // R9: load all 48 bytes during blue; color 3 writes are ignored.
        wait_row_start(2);
        for (int c = 0; c < 3; c++)
            for (int i = 0; i < NC; i++) wr(c, i, set_a[c][i]);
        for (int i = 0; i < NC; i++) wr(3, i, 8'hAA);
        push(0, set_a[0], "R9");
        push(1, set_a[1], "R9");
        push(2, set_a[2], "R9");

        // R8: green rewritten during a green period applies only from the next green period.
        wait_row_start(2);
        push(0, set_a[0], "R8");
        push(1, set_a[1], "R8");
        wait_row_start(1);
        for (int i = 0; i < NC; i++) wr(1, i, set_c[i]);
        push(2, set_a[2], "R8");
        push(0, set_a[0], "R8");
        push(1, set_c, "R8");
        push(2, set_a[2], "R8");

        while (q.size() > 0) @(negedge clk);
        repeat (256 * P + 8) @(negedge clk);
        chk(q.size() == 0, "R3", "scoreboard drained", q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule